// File: doc/BRIEF.md
# Addressed Receiver Wakeup Controller

This block sits between a serial frame receiver and the status logic on a multi-drop bus. Each node on such a bus can put its receiver to sleep through messages that are meant for other nodes. Software decides that a message is not for it and requests sleep. From then on, characters and idle-line events arriving from the frame receiver are kept from the status flags. The controller then clears the sleep bit by itself when the wake condition of the chosen method occurs.

Two wake methods are supported and chosen by one select input. In the idle-line method, an idle-line detect ends the sleep, so every node is awake when the next message starts, and that message's first character is reported as usual. In the address-mark method, a marker bit inside each character tells an address character (1) from a data character (0). A marked character ends the sleep and is itself reported, so that software can compare the address. The marker is the ninth bit when nine-bit characters are selected and the eighth bit otherwise. Address comparison and the receive shift logic are outside this block.

Top module: `rx_wake_ctrl`

## Requirements
- R1: After a synchronous reset, `sleep`, `rx_full_stb` and `idle_stb` are all 0.
- R2: A 1 on `sleep_req` at a clock edge makes `sleep` 1 from that edge on. This holds even when a wake event arrives in the same cycle.
- R3: While `sleep` is 0, a `char_done` strobe produces a one-cycle `rx_full_stb` pulse in the cycle after the strobe.
- R4: While `sleep` is 1, a character that does not meet the wake condition of the selected method produces no `rx_full_stb`, and `sleep` stays 1.
- R5: With `wake_sel`=0 (idle-line method) and `sleep` at 1, an `idle_det` strobe clears `sleep` at the same edge. The next character is then reported on `rx_full_stb`.
- R6: While `sleep` is 0, an `idle_det` strobe produces a one-cycle `idle_stb` pulse in the next cycle. While `sleep` is 1, `idle_det` produces no `idle_stb`, whatever the method.
- R7: With `wake_sel`=1 (address-mark method) and `sleep` at 1, a character whose marker bit is 1 clears `sleep` and produces `rx_full_stb`, both in the next cycle.
- R8: The marker bit is `rx_word[8]` when `len9`=1 and `rx_word[7]` when `len9`=0. The other of those two bits has no effect on waking.
- R9: With `wake_sel`=1 and `sleep` at 1, `idle_det` leaves `sleep` at 1.
- R10: With `wake_sel`=0 and `sleep` at 1, a character with its marker bit at 1 neither wakes the receiver nor is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Software write of 1 to the sleep bit |
| wake_sel | input | 1 | Wake method: 0 idle-line, 1 address-mark |
| len9 | input | 1 | 1 selects nine-bit characters, 0 eight-bit |
| char_done | input | 1 | One-cycle strobe: a character has been received |
| rx_word | input | WORD_W (9) | Received character, bit 0 first on the line |
| idle_det | input | 1 | One-cycle strobe: idle line detected |
| sleep | output | 1 | Current sleep bit |
| rx_full_stb | output | 1 | Gated receive-full strobe |
| idle_stb | output | 1 | Gated idle-line strobe |

## Verification
All three outputs are registered. A stimulus applied before edge k shows on `sleep`, `rx_full_stb` and `idle_stb` after edge k, that is, one cycle later. The bench drives inputs on the falling edge, lets one rising edge pass, and samples just after it. Before it applies the next stimulus, it compares the outputs with a bench model that has advanced by exactly that one edge. Because of this, an event that was suppressed can be seen as the missing pulse in its own cycle, and cannot be confused with a later event.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_ADDR = 1'b1
  } wake_mode_e;
endpackage

// File: rtl/wake_marker.sv
module wake_marker #(
  parameter int WORD_W = 9
) (
  input  logic [WORD_W-1:0] rx_word,
  input  logic              len9,
  output logic              marker
);
  localparam int HI_BIT = WORD_W - 1;
  localparam int LO_BIT = WORD_W - 2;

  generate
    if (WORD_W >= 2) begin : g_two_len
      always_comb marker = len9 ? rx_word[HI_BIT] : rx_word[LO_BIT];
    end else begin : g_one_len
      always_comb marker = rx_word[0] & (len9 | ~len9);
    end
  endgenerate
endmodule

// File: rtl/wake_sleep_reg.sv
module wake_sleep_reg
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  wake_mode_e mode,
  input  logic       char_done,
  input  logic       marker,
  input  logic       idle_det,
  output logic       sleep,
  output logic       pass_char,
  output logic       pass_idle
);
  logic wake_idle, wake_addr;

  always_comb begin
    wake_idle = sleep && (mode == WAKE_IDLE) && idle_det;
    wake_addr = sleep && (mode == WAKE_ADDR) && char_done && marker;
    pass_char = char_done && (!sleep || wake_addr);
    pass_idle = idle_det && !sleep;
  end

  always_ff @(posedge clk) begin
    if (rst)                       sleep <= 1'b0;
    else if (sleep_req)            sleep <= 1'b1;
    else if (wake_idle || wake_addr) sleep <= 1'b0;
  end

  // R2: a software request always leaves the receiver asleep
  a_r2_sleep_set: assert property (@(posedge clk) disable iff (rst)
    sleep_req |=> sleep);
  // R9: in address-mark mode an idle line never wakes
  a_r9_idle_no_wake: assert property (@(posedge clk) disable iff (rst)
    (sleep && mode == WAKE_ADDR && !char_done) |=> sleep);
  // R10: in idle-line mode a character never wakes
  a_r10_char_no_wake: assert property (@(posedge clk) disable iff (rst)
    (sleep && mode == WAKE_IDLE && !idle_det) |=> sleep);
endmodule

// File: rtl/wake_flag_out.sv
module wake_flag_out (
  input  logic clk,
  input  logic rst,
  input  logic pass_char,
  input  logic pass_idle,
  output logic rx_full_stb,
  output logic idle_stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full_stb <= 1'b0;
      idle_stb    <= 1'b0;
    end else begin
      rx_full_stb <= pass_char;
      idle_stb    <= pass_idle;
    end
  end
endmodule

// File: rtl/rx_wake_ctrl.sv
module rx_wake_ctrl
  import wake_pkg::*;
#(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              wake_sel,
  input  logic              len9,
  input  logic              char_done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              idle_det,
  output logic              sleep,
  output logic              rx_full_stb,
  output logic              idle_stb
);
  logic       marker, pass_char, pass_idle;
  wake_mode_e mode;

  assign mode = wake_mode_e'(wake_sel);

  wake_marker #(.WORD_W(WORD_W)) u_marker (
    .rx_word(rx_word), .len9(len9), .marker(marker));

  wake_sleep_reg u_sleep (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .mode(mode),
    .char_done(char_done), .marker(marker), .idle_det(idle_det),
    .sleep(sleep), .pass_char(pass_char), .pass_idle(pass_idle));

  wake_flag_out u_flags (
    .clk(clk), .rst(rst), .pass_char(pass_char), .pass_idle(pass_idle),
    .rx_full_stb(rx_full_stb), .idle_stb(idle_stb));

  // R3: awake receiver reports every character
  a_r3_awake_full: assert property (@(posedge clk) disable iff (rst)
    (char_done && !sleep) |=> rx_full_stb);
  // R6: idle strobe only when awake
  a_r6_idle_gate: assert property (@(posedge clk) disable iff (rst)
    idle_det |=> (idle_stb == !$past(sleep)));
  // R7: marked character wakes in address-mark mode
  a_r7_addr_wake: assert property (@(posedge clk) disable iff (rst)
    (sleep && wake_sel && char_done && marker && !sleep_req) |=> (!sleep && rx_full_stb));
  // R4: asleep without a marker, nothing is reported
  a_r4_asleep_quiet: assert property (@(posedge clk) disable iff (rst)
    (sleep && char_done && !(wake_sel && marker)) |=> !rx_full_stb);
endmodule

// File: tb/tb_rx_wake_ctrl.sv
module tb_rx_wake_ctrl;
  localparam int WORD_W = 9;
  logic clk = 0, rst = 1;
  logic sleep_req = 0, wake_sel = 0, len9 = 0, char_done = 0, idle_det = 0;
  logic [WORD_W-1:0] rx_word = '0;
  logic sleep, rx_full_stb, idle_stb;
  int checks = 0, fails = 0;
  bit m_sleep = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_wake_ctrl #(.WORD_W(WORD_W)) dut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_sel(wake_sel),
    .len9(len9), .char_done(char_done), .rx_word(rx_word), .idle_det(idle_det),
    .sleep(sleep), .rx_full_stb(rx_full_stb), .idle_stb(idle_stb));

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic bit mark_of(input logic [WORD_W-1:0] w, input bit l9);
    return l9 ? w[8] : w[7];
  endfunction

  // one cycle: drive at negedge, sample after next posedge
  task automatic step(input bit sr, input bit ws, input bit l9, input bit cd,
                      input logic [WORD_W-1:0] w, input bit id);
    bit e_full, e_idle, e_sleep, mk;
    string tag;
    @(negedge clk);
    sleep_req = sr; wake_sel = ws; len9 = l9; char_done = cd; rx_word = w; idle_det = id;
    mk = mark_of(w, l9);
    e_full = cd && (!m_sleep || (ws && mk));
    e_idle = id && !m_sleep;
    if (sr) e_sleep = 1;
    else if (m_sleep && !ws && id) e_sleep = 0;
    else if (m_sleep && ws && cd && mk) e_sleep = 0;
    else e_sleep = m_sleep;
    @(posedge clk); #1;
    if (sr) tag = "R2";
    else if (m_sleep && ws && cd && mk) tag = "R7/R8";
    else if (m_sleep && !ws && id) tag = "R5";
    else if (m_sleep && ws && id) tag = "R9";
    else if (m_sleep && !ws && cd && mk) tag = "R10";
    else if (m_sleep) tag = "R4";
    else tag = "R3/R6";
    chk(sleep, e_sleep, {tag, " sleep"});
    chk(rx_full_stb, e_full, {tag, " rx_full_stb"});
    chk(idle_stb, e_idle, {tag, " idle_stb"});
    m_sleep = e_sleep;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(sleep, 0, "R1 sleep"); chk(rx_full_stb, 0, "R1 rx_full_stb"); chk(idle_stb, 0, "R1 idle_stb");
    // R3 awake char, R6 awake idle
    step(0,0,1,1,9'h0AA,0);
    step(0,0,1,0,9'h000,1);
    // R2 sleep, R4 suppressed, R6 idle suppressed via R5 wake
    step(1,0,1,0,0,0);
    step(0,0,1,1,9'h055,0);
    step(0,0,1,1,9'h1FF,0);       // R10 marker ignored in idle mode
    step(0,0,1,0,0,1);            // R5 wake, no idle strobe
    step(0,0,1,1,9'h012,0);       // R5 next char delivered
    // address mode, nine-bit: R8 bit7 set only -> no wake
    step(1,1,1,0,0,0);
    step(0,1,1,1,9'h080,0);
    step(0,1,1,0,0,1);            // R9
    step(0,1,1,1,9'h100,0);       // R7 wake
    // eight-bit: bit8 ignored, bit7 is marker (R8)
    step(1,1,0,0,0,0);
    step(0,1,0,1,9'h100,0);
    step(0,1,0,1,9'h080,0);
    // R2 priority over wake in same cycle
    step(1,1,0,0,0,0);
    step(1,1,0,1,9'h080,0);
    step(1,0,0,0,0,1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
           WORD_W'($urandom), ($urandom % 5) == 0);
    end
    // R1 again: reset mid-run
    @(negedge clk); rst = 1; sleep_req = 1;
    @(posedge clk); #1;
    chk(sleep, 0, "R1 sleep"); chk(rx_full_stb, 0, "R1 rx_full_stb"); chk(idle_stb, 0, "R1 idle_stb");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule